// File: doc/BRIEF.md
# Mix-Selected Raster Operation Unit

This block merges three bytes, a pattern byte, a source byte and a destination byte, into one result byte under an 8-bit raster operation code. Each of the eight bit positions is worked out on its own: the three operand bits at that position form a 3-bit index, and the result bit is the code bit at that index. Any of the 256 Boolean functions of three inputs can be selected this way, including copy, invert, XOR and masking.

Two operation codes are held at the inputs, a foreground code and a background code. A 32-bit mix mask picks one of them for each byte. Bit 0 of the mask makes the choice, and the mask moves down by one place for every byte taken, with a 1 entering at the top. After reset the mask holds all ones, so every byte uses the foreground code until a mask is loaded. The source byte comes either from the operand stream or from a 32-bit word loaded by the CPU. In CPU-source mode the word gives up its low byte first and then shifts right by eight bits.

The operand stream uses a valid/ready handshake, and so does the result stream. A byte transfers on a rising edge where both valid and ready are high. The input is ready whenever the single output register is empty or is being drained in the same cycle, so back-pressure on the output stalls the input with no extra buffering. The code, mode and load pins are plain control pins.

Top module: `rop_mix_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, the mix mask is all ones (the first bytes use fg_rop) and the CPU word is zero.
- R2: For each bit position i, the result bit equals bit {pat[i],src[i],dst[i]} of the selected code, where pat is the index MSB and dst the LSB (copy pattern = 8'hF0, copy source = 8'hCC, keep destination = 8'hAA).
- R3: A byte is processed with fg_rop when bit 0 of the mix mask is 1 at acceptance, and with bg_rop when it is 0.
- R4: Each accepted byte shifts the mix mask right by one and sets bit 31 to 1, so after 32 bytes with no reload every byte uses fg_rop.
- R5: With cpu_src_mode high, the source operand is bits [7:0] of the CPU word, in_src has no effect, and each accepted byte shifts the word right by 8 with zeros entering at the top.
- R6: mix_load replaces the mask with mix_value, and cpu_load replaces the CPU word with cpu_value; each load takes priority over a shift in the same cycle, and the byte accepted in that cycle still uses the old value.
- R7: out_valid rises, with the result on out_byte, on the clock edge after the edge where a byte is accepted.
- R8: While out_valid is 1 and out_ready is 0, out_byte and out_valid hold and in_ready is 0.
- R9: With cpu_src_mode low, in_src is the source operand and the CPU word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fg_rop | input | 8 | Foreground operation code |
| bg_rop | input | 8 | Background operation code |
| mix_load | input | 1 | Load the mix mask from mix_value |
| mix_value | input | 32 | New mix mask |
| cpu_load | input | 1 | Load the CPU word from cpu_value |
| cpu_value | input | 32 | New CPU source word |
| cpu_src_mode | input | 1 | 1: source comes from the CPU word; 0: from in_src |
| in_valid | input | 1 | Operand bytes are valid |
| in_ready | output | 1 | The unit can accept operands |
| in_pat | input | 8 | Pattern byte |
| in_src | input | 8 | Source byte |
| in_dst | input | 8 | Destination byte |
| out_valid | output | 1 | Result byte is valid |
| out_ready | input | 1 | Downstream takes the result |
| out_byte | output | 8 | Result byte |

## Verification
Each result is due exactly one edge after the edge that accepted its operands, and mask and word updates take effect for the very next accepted byte. The driver puts the expected byte in a queue at the accepting edge, using the mask and word values held before that edge. It then checks out_valid at the following falling edge. The monitor samples at a falling edge only when out_valid and out_ready are both high, so a result held under back-pressure is compared once, at the edge where it leaves the unit.

// File: rtl/rop_mix_pkg.sv
package rop_mix_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 1 << 3;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef struct packed {
    byte_t pat;
    byte_t src;
    byte_t dst;
  } operands_t;
endpackage

// File: rtl/rop_bit_eval.sv
module rop_bit_eval #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] pat,
  input  logic [BYTE_W-1:0] src,
  input  logic [BYTE_W-1:0] dst,
  input  logic [7:0]        code,
  output logic [BYTE_W-1:0] result
);
  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    logic [2:0] idx;
    assign idx       = {pat[g], src[g], dst[g]};
    assign result[g] = code[idx];
  end
endmodule

// File: rtl/rop_mix_sel.sv
module rop_mix_sel #(
  parameter int MIX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MIX_W-1:0] load_val,
  input  logic             shift,
  output logic             use_fg
);
  logic [MIX_W-1:0] mix_q;
  logic [MIX_W-1:0] mix_d;

  always_comb begin
    mix_d = mix_q;
    if (load)       mix_d = load_val;
    else if (shift) mix_d = {1'b1, mix_q[MIX_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mix_q <= '1;
    else        mix_q <= mix_d;
  end

  assign use_fg = mix_q[0];

  // R6: a load wins over a shift in the same cycle
  a_r6_mix_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> mix_q == $past(load_val));
  // R4: a shift brings a 1 in at the top
  a_r4_mix_fill_one: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> mix_q[MIX_W-1] && (mix_q[MIX_W-2:0] == $past(mix_q[MIX_W-1:1])));
  // R4: without a shift or a load the mask stays put
  a_r4_mix_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !load) |=> $stable(mix_q));
endmodule

// File: rtl/rop_cpu_src.sv
module rop_cpu_src #(
  parameter int CPU_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CPU_W-1:0]  load_val,
  input  logic              shift,
  output logic [BYTE_W-1:0] src_byte
);
  logic [CPU_W-1:0] word_q;
  logic [CPU_W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (load)       word_d = load_val;
    else if (shift) word_d = word_q >> BYTE_W;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign src_byte = word_q[BYTE_W-1:0];

  // R5: consuming a byte exposes the next one
  a_r5_cpu_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> word_q[CPU_W-BYTE_W-1:0] == $past(word_q[CPU_W-1:BYTE_W]));
  // R9: the word holds when nothing is consumed
  a_r9_cpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !load) |=> $stable(word_q));
endmodule

// File: rtl/rop_mix_unit.sv
module rop_mix_unit
  import rop_mix_pkg::*;
#(
  parameter int MIX_W = 32,
  parameter int CPU_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        fg_rop,
  input  logic [7:0]        bg_rop,
  input  logic              mix_load,
  input  logic [MIX_W-1:0]  mix_value,
  input  logic              cpu_load,
  input  logic [CPU_W-1:0]  cpu_value,
  input  logic              cpu_src_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_pat,
  input  logic [BYTE_W-1:0] in_src,
  input  logic [BYTE_W-1:0] in_dst,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_byte
);
  logic        accept;
  logic        use_fg;
  byte_t       cpu_byte;
  operands_t   ops;
  logic [7:0]  code;
  byte_t       result;
  logic        valid_q;
  byte_t       byte_q;

  assign in_ready = !valid_q || out_ready;
  assign accept   = in_valid && in_ready;

  rop_mix_sel #(.MIX_W(MIX_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .load(mix_load), .load_val(mix_value),
    .shift(accept), .use_fg(use_fg)
  );

  rop_cpu_src #(.CPU_W(CPU_W), .BYTE_W(BYTE_W)) u_cpu (
    .clk(clk), .rst_n(rst_n), .load(cpu_load), .load_val(cpu_value),
    .shift(accept && cpu_src_mode), .src_byte(cpu_byte)
  );

  always_comb begin
    ops.pat = in_pat;
    ops.src = cpu_src_mode ? cpu_byte : in_src;
    ops.dst = in_dst;
    code    = use_fg ? fg_rop : bg_rop;
  end

  rop_bit_eval #(.BYTE_W(BYTE_W)) u_eval (
    .pat(ops.pat), .src(ops.src), .dst(ops.dst), .code(code), .result(result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      byte_q  <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      byte_q  <= result;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid = valid_q;
  assign out_byte  = byte_q;

  // R7: a result follows every accepted byte
  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R8: a stalled result is held unchanged
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_byte));
  // R7: a drained output with no new byte goes empty
  a_r7_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/rop_mix_unit_test.sv
module rop_mix_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  fg_rop = 8'hF0, bg_rop = 8'hAA;
  logic        mix_load = 1'b0, cpu_load = 1'b0, cpu_src_mode = 1'b0;
  logic [31:0] mix_value = '0, cpu_value = '0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic [7:0]  in_pat = '0, in_src = '0, in_dst = '0;
  logic        in_ready, out_valid;
  logic [7:0]  out_byte;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_mix = '1;
  logic [31:0] m_cpu = '0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rop_mix_unit uut (
    .clk(clk), .rst_n(rst_n), .fg_rop(fg_rop), .bg_rop(bg_rop),
    .mix_load(mix_load), .mix_value(mix_value), .cpu_load(cpu_load),
    .cpu_value(cpu_value), .cpu_src_mode(cpu_src_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_pat(in_pat), .in_src(in_src), .in_dst(in_dst),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  function automatic logic [7:0] rop_ref(input logic [7:0] c, input logic [7:0] p,
                                         input logic [7:0] s, input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = c[{p[i], s[i], d[i]}];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: offers one operand set, optionally with loads, and queues the expected result
  task automatic send(input logic [7:0] p, input logic [7:0] s, input logic [7:0] d,
                      input string req, input bit ml = 0, input logic [31:0] mv = '0,
                      input bit cl = 0, input logic [31:0] cv = '0);
    bit done = 0;
    @(negedge clk);
    in_valid = 1; in_pat = p; in_src = s; in_dst = d;
    mix_load = ml; mix_value = mv; cpu_load = cl; cpu_value = cv;
    while (!done) begin
      #1;
      if (in_ready) begin
        exp_q.push_back(rop_ref(m_mix[0] ? fg_rop : bg_rop, p,
                                cpu_src_mode ? m_cpu[7:0] : s, d));
        tag_q.push_back(req);
        m_mix = ml ? mv : {1'b1, m_mix[31:1]};
        m_cpu = cl ? cv : (cpu_src_mode ? (m_cpu >> 8) : m_cpu);
        done = 1;
      end
      @(negedge clk);
    end
    in_valid = 0; mix_load = 0; cpu_load = 0;
    #1;
    check(out_valid === 1'b1, "R7", {31'd0, out_valid}, 32'd1);
  endtask

  task automatic load_mix(input logic [31:0] v);
    @(negedge clk); mix_load = 1; mix_value = v;
    @(negedge clk); mix_load = 0; m_mix = v;
  endtask

  task automatic load_cpu(input logic [31:0] v);
    @(negedge clk); cpu_load = 1; cpu_value = v;
    @(negedge clk); cpu_load = 0; m_cpu = v;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  // monitor: compares each result at the edge where it leaves the unit
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R7", {24'd0, out_byte}, 32'hx);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          check(out_byte === e, t, {24'd0, out_byte}, {24'd0, e});
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(out_valid === 1'b0, "R1", {31'd0, out_valid}, 0);
    check(in_ready === 1'b1, "R1", {31'd0, in_ready}, 1);
    // R1: reset mask selects foreground (pattern copy)
    send(8'h3C, 8'h55, 8'h0F, "R1");
    send(8'hA5, 8'hFF, 8'h00, "R1");
    // R2: assorted codes over assorted operands
    for (int k = 0; k < 12; k++) begin
      fg_rop = 8'h17 * k + 8'h2B;
      send(8'h1F * k, 8'hC3 ^ (8'h11 * k), 8'h96 + k, "R2");
    end
    drain();
    // R3 / R4: alternating mask, then past 32 bytes all foreground
    fg_rop = 8'hF0; bg_rop = 8'hAA;
    load_mix(32'h0000_0005);
    for (int k = 0; k < 6; k++) send(8'hF0, 8'h33, 8'h0F ^ k, "R3");
    for (int k = 0; k < 30; k++) send(8'h5A + k, 8'h00, 8'hC3, "R4");
    load_mix(32'h0000_0000);
    for (int k = 0; k < 36; k++) send(8'hFF, 8'h00, 8'h00, "R4");
    drain();
    // R5: CPU word consumed low byte first, in_src has no effect
    fg_rop = 8'hCC;
    load_cpu(32'h4433_2211);
    cpu_src_mode = 1;
    for (int k = 0; k < 5; k++) send(8'h00, 8'hEE - k, 8'hFF, "R5");
    // R9: memory mode uses in_src and keeps the word
    load_cpu(32'hDDCC_BBAA);
    cpu_src_mode = 0;
    send(8'h00, 8'h12, 8'h00, "R9");
    send(8'h00, 8'h34, 8'h00, "R9");
    drain();
    cpu_src_mode = 1;
    send(8'h00, 8'h00, 8'h00, "R9");
    // R6: loads in the same cycle as an accepted byte
    bg_rop = 8'h00; fg_rop = 8'hCC;
    send(8'h00, 8'h00, 8'h00, "R6", 1, 32'hFFFF_FFFE, 1, 32'h0000_0077);
    send(8'h00, 8'h00, 8'h00, "R6");
    send(8'h00, 8'h00, 8'h00, "R6");
    drain();
    // R8: back-pressure
    cpu_src_mode = 0; fg_rop = 8'h66;
    out_ready = 0;
    send(8'h00, 8'hF0, 8'h3C, "R8");
    @(negedge clk); #1;
    begin
      logic [7:0] held;
      held = out_byte;
      check(in_ready === 1'b0, "R8", {31'd0, in_ready}, 0);
      repeat (3) @(negedge clk);
      #1;
      check(out_valid === 1'b1 && out_byte === held, "R8", {24'd0, out_byte}, {24'd0, held});
    end
    fork
      send(8'h00, 8'h0F, 8'h3C, "R8");
      begin repeat (3) @(negedge clk); out_ready = 1; end
    join
    drain();
    check(exp_q.size() == 0, "R7", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule